// File: doc/BRIEF.md
# Address-Space-Tagged Unified Translation Buffer

This block holds a fully associative set of page translations, each tagged with a virtual page number, an 8-bit address-space identifier, a physical page number, a 9-bit attribute field and a page size of 1 KB, 4 KB, 64 KB or 1 MB. A lookup presents a virtual address together with the current address-space identifier. Every entry is compared in parallel, and the block reports one of three outcomes in the same cycle: a single hit, with its index and the translated physical address; a miss; or a multiple hit.

Entries are filled in three ways. A load port copies a page-table-entry pair into the slot named by a replacement index. A memory-mapped array port gives direct read and write access to the address half and the data half of any entry. That port also has an associative write mode, which locates an entry by tag and changes only its valid and dirty bits. A global invalidate input clears every valid bit at once.

Top module: `utlb_xlat`

## Requirements
- R1: An entry matches a lookup when its valid attribute (bit 8) is set, when its shared attribute (bit 1) is set or its identifier equals `lk_asid`, and when its page number agrees with `lk_va[31:10]` on every bit that the entry's page mask keeps.
- R2: The size code {attribute bit 7, attribute bit 4} selects the compared address bits: 00 compares `lk_va[31:10]`, 01 compares `[31:12]`, 10 compares `[31:16]` and 11 compares `[31:20]`. The bits below the compared range pass from the virtual to the physical address unchanged.
- R3: Exactly one of `lk_hit`, `lk_miss` and `lk_multi` is high, in the same cycle as the lookup inputs. On a hit, `lk_index` names the matching entry and `lk_pa` is the entry's physical page on the compared bits, with the virtual address supplying the rest.
- R4: When `lk_sv_mode` and `lk_priv` are both high, the identifier compare is skipped. If either is low, the identifier compare applies.
- R5: When `load_en` is high, the entry at `load_idx` takes `pte_hi[31:10]` as its page number, `pte_hi[7:0]` as its identifier, `pte_lo[28:10]` as its physical page and `pte_lo[8:0]` as its attributes, at the next rising edge. Attribute bit 2 is the dirty bit.
- R6: If a written physical page is 0x1C000000 or higher (`[28:26]` all ones), the stored physical page has bits 31:29 forced to ones. Otherwise those bits are zero.
- R7: On the array port, `arr_offs[6:1]` (address bits 13:8) select the entry, `arr_offs[0]` (address bit 7) selects associative mode, and `arr_sel_data` selects the data half. An address-half read returns {page number, dirty at bit 9, valid at bit 8, identifier}. A data-half read returns {000, physical page bits 28:10, 0, attributes}.
- R8: A direct address-half write sets the page number from `arr_wdata[31:10]`, the identifier from `[7:0]`, valid from `[8]` and dirty from `[9]`, and leaves the other attributes alone. A data-half write sets the physical page from `[28:10]` (subject to R6) and the attributes from `[8:0]`.
- R9: An associative address-half write compares `arr_wdata[31:10]` with `lk_asid` under the R1 rule, with the identifier never skipped. If exactly one entry matches, only that entry's valid bit (from `[8]`) and dirty bit (from `[9]`) change. If no entry or several entries match, nothing changes.
- R10: `inval_all` clears the valid bit of every entry at the next edge. Page numbers, identifiers and other fields are left in place.
- R11: When several writes are requested in one cycle, `inval_all` takes precedence over `load_en`, and `load_en` takes precedence over `arr_wr_en`. The losing requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_sv_mode | input | 1 | Single-virtual-space control bit |
| lk_priv | input | 1 | Access is privileged |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_multi | output | 1 | More than one entry matched |
| lk_index | output | 6 | Index of matching entry (lowest match, 0 if none) |
| lk_pa | output | 32 | Translated physical address |
| load_en | input | 1 | Load page-table-entry pair |
| load_idx | input | 6 | Replacement index for the load |
| pte_hi | input | 32 | Tag half of the entry to load |
| pte_lo | input | 32 | Data half of the entry to load |
| arr_wr_en | input | 1 | Array port write strobe |
| arr_sel_data | input | 1 | 1 selects the data half, 0 the address half |
| arr_offs | input | 7 | Array access address bits 13:7 |
| arr_wdata | input | 32 | Array write data |
| arr_rdata | output | 32 | Array read data, combinational |
| inval_all | input | 1 | Invalidate every entry |

## Verification
Lookup results and array reads are combinational from the stored entries, so they are due in the same cycle as their inputs. The bench drives them on the falling edge and samples them one nanosecond later. Load, array write and invalidate take effect at the next rising edge. The bench updates its own entry model at that edge and makes its following lookups and read-backs only after it, so every write is checked one edge after it was applied.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VPN_W  = 22;
    localparam int PPN_W  = 22;
    localparam int ASID_W = 8;
    localparam int ATTR_W = 9;

    // attribute bit positions
    localparam int AT_VALID  = 8;
    localparam int AT_SZ_HI  = 7;
    localparam int AT_SZ_LO  = 4;
    localparam int AT_DIRTY  = 2;
    localparam int AT_SHARED = 1;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MULTI = 2'd2
    } lk_res_e;

    // page-number bits kept for comparison, per size code
    function automatic logic [VPN_W-1:0] page_keep(input logic [ATTR_W-1:0] attr);
        logic [VPN_W-1:0] m;
        case ({attr[AT_SZ_HI], attr[AT_SZ_LO]})
            2'b00:   m = '1;
            2'b01:   m = ~VPN_W'(22'h3);
            2'b10:   m = ~VPN_W'(22'h3F);
            default: m = ~VPN_W'(22'h3FF);
        endcase
        return m;
    endfunction

    // high physical pages get their top bits forced
    function automatic logic [PPN_W-1:0] ppn_extend(input logic [PPN_W-4:0] raw);
        return {(raw[PPN_W-4 -: 3] == 3'b111) ? 3'b111 : 3'b000, raw};
    endfunction

    function automatic logic ent_matches(input tlb_ent_t e,
                                         input logic [VPN_W-1:0] vpn,
                                         input logic [ASID_W-1:0] asid,
                                         input logic skip_asid);
        return e.attr[AT_VALID]
            && (skip_asid || e.attr[AT_SHARED] || (e.asid == asid))
            && (((e.vpn ^ vpn) & page_keep(e.attr)) == '0);
    endfunction

endpackage

// File: rtl/tlb_match_array.sv
module tlb_match_array
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64
) (
    input  tlb_ent_t           ents [N_ENT],
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASID_W-1:0]  asid,
    input  logic               skip_asid,
    output logic [N_ENT-1:0]   hits
);

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hits[g] = ent_matches(ents[g], vpn, asid, skip_asid);
    end

endmodule

// File: rtl/tlb_hit_encode.sv
module tlb_hit_encode
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_ENT-1:0]  hits,
    output lk_res_e           res,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (hits == '0)          res = RES_MISS;
        else if ($onehot(hits))  res = RES_HIT;
        else                     res = RES_MULTI;
    end

    // R3
    hit_index_chk: assert property (@(posedge clk) disable iff (rst)
        (res == RES_HIT) |-> hits[idx]);

    // R3
    multi_count_chk: assert property (@(posedge clk) disable iff (rst)
        (res == RES_MULTI) |-> ($countones(hits) > 1));

    // R3
    miss_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (res == RES_MISS) |-> !$onehot0(hits) == 1'b0);

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inval_all,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [31:0]       pte_hi,
    input  logic [31:0]       pte_lo,
    input  logic              arr_wr_en,
    input  logic              arr_sel_data,
    input  logic              arr_assoc,
    input  logic [IDX_W-1:0]  arr_idx,
    input  logic [31:0]       arr_wdata,
    input  logic              assoc_single,
    input  logic [IDX_W-1:0]  assoc_idx,
    output tlb_ent_t          ents_o [N_ENT]
);

    tlb_ent_t          ents_q [N_ENT];
    logic [N_ENT-1:0]  valid_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ents_q[i] <= '0;
        end else if (inval_all) begin
            for (int i = 0; i < N_ENT; i++) ents_q[i].attr[AT_VALID] <= 1'b0;
        end else if (load_en) begin
            ents_q[load_idx].vpn  <= pte_hi[31:10];
            ents_q[load_idx].asid <= pte_hi[7:0];
            ents_q[load_idx].ppn  <= ppn_extend(pte_lo[28:10]);
            ents_q[load_idx].attr <= pte_lo[8:0];
        end else if (arr_wr_en) begin
            if (arr_sel_data) begin
                ents_q[arr_idx].ppn  <= ppn_extend(arr_wdata[28:10]);
                ents_q[arr_idx].attr <= arr_wdata[8:0];
            end else if (arr_assoc) begin
                if (assoc_single) begin
                    ents_q[assoc_idx].attr[AT_VALID] <= arr_wdata[8];
                    ents_q[assoc_idx].attr[AT_DIRTY] <= arr_wdata[9];
                end
            end else begin
                ents_q[arr_idx].vpn            <= arr_wdata[31:10];
                ents_q[arr_idx].asid           <= arr_wdata[7:0];
                ents_q[arr_idx].attr[AT_VALID] <= arr_wdata[8];
                ents_q[arr_idx].attr[AT_DIRTY] <= arr_wdata[9];
            end
        end
    end

    assign ents_o = ents_q;

    for (genvar g = 0; g < N_ENT; g++) begin : g_vld
        assign valid_vec[g] = ents_q[g].attr[AT_VALID];

        // R9
        assoc_keeps_tag_chk: assert property (@(posedge clk) disable iff (rst)
            (arr_wr_en && !arr_sel_data && arr_assoc && !inval_all && !load_en)
            |=> ($stable(ents_q[g].vpn) && $stable(ents_q[g].asid) && $stable(ents_q[g].ppn)));
    end

    // R10
    inval_clears_chk: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> (valid_vec == '0));

    // R5
    load_writes_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && !inval_all) |=> (ents_q[$past(load_idx)].vpn == $past(pte_hi[31:10])
                                     && ents_q[$past(load_idx)].asid == $past(pte_hi[7:0])));

    // R11
    inval_beats_load_chk: assert property (@(posedge clk) disable iff (rst)
        (inval_all && load_en) |=> !ents_q[$past(load_idx)].attr[AT_VALID]);

endmodule

// File: rtl/utlb_xlat.sv
module utlb_xlat
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       lk_va,
    input  logic [7:0]        lk_asid,
    input  logic              lk_sv_mode,
    input  logic              lk_priv,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_multi,
    output logic [IDX_W-1:0]  lk_index,
    output logic [31:0]       lk_pa,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [31:0]       pte_hi,
    input  logic [31:0]       pte_lo,
    input  logic              arr_wr_en,
    input  logic              arr_sel_data,
    input  logic [IDX_W:0]    arr_offs,
    input  logic [31:0]       arr_wdata,
    output logic [31:0]       arr_rdata,
    input  logic              inval_all
);

    tlb_ent_t          ents [N_ENT];
    logic [N_ENT-1:0]  lk_hits;
    logic [N_ENT-1:0]  as_hits;
    lk_res_e           lk_res;
    lk_res_e           as_res;
    logic [IDX_W-1:0]  as_idx;
    logic [IDX_W-1:0]  arr_idx;
    logic              arr_assoc;
    tlb_ent_t          hit_ent;
    tlb_ent_t          rd_ent;
    logic [VPN_W-1:0]  keep;
    logic              unused_bits;

    assign arr_idx   = arr_offs[IDX_W:1];
    assign arr_assoc = arr_offs[0];
    assign unused_bits = ^{pte_hi[9:8], pte_lo[31:29], pte_lo[9]};

    tlb_entry_store #(.N_ENT(N_ENT)) store_i (
        .clk          (clk),
        .rst          (rst),
        .inval_all    (inval_all),
        .load_en      (load_en),
        .load_idx     (load_idx),
        .pte_hi       (pte_hi),
        .pte_lo       (pte_lo),
        .arr_wr_en    (arr_wr_en),
        .arr_sel_data (arr_sel_data),
        .arr_assoc    (arr_assoc),
        .arr_idx      (arr_idx),
        .arr_wdata    (arr_wdata),
        .assoc_single (as_res == RES_HIT),
        .assoc_idx    (as_idx),
        .ents_o       (ents)
    );

    tlb_match_array #(.N_ENT(N_ENT)) lk_cmp_i (
        .ents      (ents),
        .vpn       (lk_va[31:10]),
        .asid      (lk_asid),
        .skip_asid (lk_sv_mode && lk_priv),
        .hits      (lk_hits)
    );

    tlb_match_array #(.N_ENT(N_ENT)) as_cmp_i (
        .ents      (ents),
        .vpn       (arr_wdata[31:10]),
        .asid      (lk_asid),
        .skip_asid (1'b0),
        .hits      (as_hits)
    );

    tlb_hit_encode #(.N_ENT(N_ENT)) lk_enc_i (
        .clk (clk),
        .rst (rst),
        .hits(lk_hits),
        .res (lk_res),
        .idx (lk_index)
    );

    tlb_hit_encode #(.N_ENT(N_ENT)) as_enc_i (
        .clk (clk),
        .rst (rst),
        .hits(as_hits),
        .res (as_res),
        .idx (as_idx)
    );

    assign lk_hit   = (lk_res == RES_HIT);
    assign lk_miss  = (lk_res == RES_MISS);
    assign lk_multi = (lk_res == RES_MULTI);

    assign hit_ent = ents[lk_index];
    assign keep    = page_keep(hit_ent.attr);
    assign lk_pa   = {(hit_ent.ppn & keep) | (lk_va[31:10] & ~keep), lk_va[9:0]};

    assign rd_ent = ents[arr_idx];
    always_comb begin
        if (arr_sel_data)
            arr_rdata = {3'b000, rd_ent.ppn[PPN_W-4:0], 1'b0, rd_ent.attr};
        else
            arr_rdata = {rd_ent.vpn, rd_ent.attr[AT_DIRTY], rd_ent.attr[AT_VALID], rd_ent.asid};
    end

    // R3
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({lk_hit, lk_miss, lk_multi}) == 1);

    // R1
    hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> hit_ent.attr[AT_VALID]);

endmodule

// File: tb/utlb_xlat_tb_top.sv
module utlb_xlat_tb_top;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_va;
    logic [7:0]  lk_asid;
    logic        lk_sv_mode, lk_priv;
    logic        lk_hit, lk_miss, lk_multi;
    logic [5:0]  lk_index;
    logic [31:0] lk_pa;
    logic        load_en;
    logic [5:0]  load_idx;
    logic [31:0] pte_hi, pte_lo;
    logic        arr_wr_en, arr_sel_data;
    logic [6:0]  arr_offs;
    logic [31:0] arr_wdata, arr_rdata;
    logic        inval_all;

    int n_cmp = 0;
    int n_bad = 0;

    logic [21:0] r_vpn  [N];
    logic [7:0]  r_asid [N];
    logic [21:0] r_ppn  [N];
    logic [8:0]  r_attr [N];

    always #5 clk = ~clk;

    utlb_xlat dut_i (
        .clk(clk), .rst(rst), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_sv_mode(lk_sv_mode), .lk_priv(lk_priv), .lk_hit(lk_hit),
        .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_index(lk_index),
        .lk_pa(lk_pa), .load_en(load_en), .load_idx(load_idx),
        .pte_hi(pte_hi), .pte_lo(pte_lo), .arr_wr_en(arr_wr_en),
        .arr_sel_data(arr_sel_data), .arr_offs(arr_offs),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .inval_all(inval_all)
    );

    function automatic logic [21:0] m_keep(input logic [8:0] a);
        case ({a[7], a[4]})
            2'b00: return 22'h3FFFFF;
            2'b01: return 22'h3FFFFC;
            2'b10: return 22'h3FFFC0;
            default: return 22'h3FFC00;
        endcase
    endfunction

    function automatic logic [21:0] m_ext(input logic [18:0] p);
        return (p[18:16] == 3'b111) ? {3'b111, p} : {3'b000, p};
    endfunction

    function automatic bit m_match(input int i, input logic [21:0] v,
                                   input logic [7:0] a, input bit skip);
        return r_attr[i][8] && (skip || r_attr[i][1] || r_asid[i] == a)
            && (((r_vpn[i] ^ v) & m_keep(r_attr[i])) == 22'h0);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        load_en = 0; arr_wr_en = 0; inval_all = 0; arr_sel_data = 0;
        arr_offs = 0; arr_wdata = 0; load_idx = 0; pte_hi = 0; pte_lo = 0;
    endtask

    task automatic do_load(input logic [5:0] idx, input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        load_en = 1; load_idx = idx; pte_hi = hi; pte_lo = lo;
        @(posedge clk); #1;
        r_vpn[idx] = hi[31:10]; r_asid[idx] = hi[7:0];
        r_ppn[idx] = m_ext(lo[28:10]); r_attr[idx] = lo[8:0];
        idle();
    endtask

    task automatic do_inval();
        @(negedge clk);
        inval_all = 1;
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) r_attr[i][8] = 1'b0;
        idle();
    endtask

    task automatic do_arr(input bit sel_d, input logic [6:0] offs,
                          input logic [31:0] w, input logic [7:0] asid);
        int cnt;
        int hit_i;
        @(negedge clk);
        arr_wr_en = 1; arr_sel_data = sel_d; arr_offs = offs; arr_wdata = w; lk_asid = asid;
        cnt = 0; hit_i = 0;
        for (int i = 0; i < N; i++)
            if (m_match(i, w[31:10], asid, 0)) begin cnt++; hit_i = i; end
        @(posedge clk); #1;
        if (sel_d) begin
            r_ppn[offs[6:1]] = m_ext(w[28:10]);
            r_attr[offs[6:1]] = w[8:0];
        end else if (offs[0]) begin
            if (cnt == 1) begin r_attr[hit_i][8] = w[8]; r_attr[hit_i][2] = w[9]; end
        end else begin
            r_vpn[offs[6:1]] = w[31:10]; r_asid[offs[6:1]] = w[7:0];
            r_attr[offs[6:1]][8] = w[8]; r_attr[offs[6:1]][2] = w[9];
        end
        idle();
    endtask

    task automatic chk_lookup(input logic [31:0] va, input logic [7:0] asid,
                              input bit sv, input bit pv, input string tag);
        int cnt;
        int first;
        logic [21:0] k;
        logic [31:0] epa;
        @(negedge clk);
        lk_va = va; lk_asid = asid; lk_sv_mode = sv; lk_priv = pv;
        #1;
        cnt = 0; first = -1;
        for (int i = 0; i < N; i++)
            if (m_match(i, va[31:10], asid, sv && pv)) begin
                cnt++;
                if (first < 0) first = i;
            end
        check({lk_hit, lk_miss, lk_multi} == {cnt == 1, cnt == 0, cnt > 1},
              {tag, " R3 outcome"}, {lk_hit, lk_miss, lk_multi},
              {cnt == 1, cnt == 0, cnt > 1});
        if (cnt == 1 && lk_hit) begin
            k = m_keep(r_attr[first]);
            epa = {(r_ppn[first] & k) | (va[31:10] & ~k), va[9:0]};
            check(lk_index == 6'(first), {tag, " R3 index"}, lk_index, first);
            check(lk_pa == epa, {tag, " R2 pa"}, lk_pa, epa);
        end
    endtask

    task automatic chk_read(input bit sel_d, input logic [5:0] idx, input string tag);
        logic [31:0] e;
        @(negedge clk);
        arr_sel_data = sel_d; arr_offs = {idx, 1'b0};
        #1;
        if (sel_d) e = {3'b000, r_ppn[idx][18:0], 1'b0, r_attr[idx]};
        else       e = {r_vpn[idx], r_attr[idx][2], r_attr[idx][8], r_asid[idx]};
        check(arr_rdata == e, {tag, " R7 read"}, arr_rdata, e);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [21:0] pool [8];
        void'($urandom(32'd7130));
        for (int i = 0; i < N; i++) begin
            r_vpn[i] = 0; r_asid[i] = 0; r_ppn[i] = 0; r_attr[i] = 0;
        end
        idle();
        lk_va = 0; lk_asid = 0; lk_sv_mode = 0; lk_priv = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // reset state
        chk_lookup(32'h0000_0000, 8'h00, 0, 0, "reset R1");
        chk_read(0, 6'd0, "reset");
        chk_read(1, 6'd63, "reset");

        // R1/R5 basic load then hit, ASID mismatch misses
        do_load(6'd3, 32'h1234_5C01, 32'h0ABC_D100);
        chk_lookup(32'h1234_5C7F, 8'h01, 0, 0, "R1 R5 hit");
        chk_lookup(32'h1234_5C7F, 8'h02, 0, 0, "R1 asid miss");
        // R4 skip identifier only when sv and priv
        chk_lookup(32'h1234_5C7F, 8'h02, 1, 1, "R4 sv priv");
        chk_lookup(32'h1234_5C7F, 8'h02, 1, 0, "R4 sv user");
        check(lk_miss === 1'b1, "R4 sv user miss", lk_miss, 1);
        // shared bit
        do_load(6'd9, 32'h4000_0007, 32'h0000_0102);
        chk_lookup(32'h4000_03FF, 8'h55, 0, 0, "R1 shared");
        // R2 1M page
        do_load(6'd20, 32'h8010_0004, 32'h0230_0190);
        chk_lookup(32'h801A_BCDE, 8'h04, 0, 0, "R2 1M");
        check(lk_pa == 32'h023A_BCDE, "R2 1M pa", lk_pa, 32'h023A_BCDE);
        // R6 high page fixup
        do_load(6'd5, 32'h0040_0001, 32'h1C00_0100);
        chk_lookup(32'h0040_0123, 8'h01, 0, 0, "R6 high");
        check(lk_pa == 32'hFC00_0123, "R6 high pa", lk_pa, 32'hFC00_0123);
        do_load(6'd6, 32'h0080_0001, 32'h1BFF_FD00);
        chk_lookup(32'h0080_0042, 8'h01, 0, 0, "R6 below");
        check(lk_pa == 32'h1BFF_FC42, "R6 below pa", lk_pa, 32'h1BFF_FC42);
        chk_read(1, 6'd5, "R6");
        // multi-hit
        do_load(6'd40, 32'h1234_5C01, 32'h0000_0110);
        chk_lookup(32'h1234_5C00, 8'h01, 0, 0, "R3 multi");
        check(lk_multi === 1'b1, "R3 multi flag", lk_multi, 1);
        // R9 assoc on multi: nothing changes
        do_arr(0, 7'h01, 32'h1234_5C00, 8'h01);
        chk_read(0, 6'd3, "R9 multi nochange");
        // R9 assoc single: clear valid of entry 40 with dirty set
        do_arr(0, 7'h01, 32'h0000_0000, 8'h00);
        do_load(6'd3, 32'h1234_5C01, 32'h0ABC_D000);
        do_arr(0, 7'h01, 32'h1234_5E00, 8'h01);
        chk_read(0, 6'd40, "R9 single");
        chk_read(1, 6'd40, "R9 single data");
        chk_lookup(32'h1234_5C00, 8'h01, 0, 0, "R9 after");
        // R8 direct writes
        do_arr(0, {6'd11, 1'b0}, 32'h7777_7F33, 8'h00);
        do_arr(1, {6'd11, 1'b0}, 32'h0135_7D40, 8'h00);
        chk_read(0, 6'd11, "R8 addr");
        chk_read(1, 6'd11, "R8 data");
        chk_lookup(32'h7777_7C99, 8'h33, 0, 0, "R8 lookup");
        // R11 priority
        @(negedge clk);
        inval_all = 1; load_en = 1; load_idx = 6'd50; pte_hi = 32'hAAAA_A401; pte_lo = 32'h0000_0100;
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) r_attr[i][8] = 1'b0;
        idle();
        chk_lookup(32'hAAAA_A400, 8'h01, 0, 0, "R11 inval wins");
        check(lk_miss === 1'b1, "R11 miss", lk_miss, 1);
        @(negedge clk);
        load_en = 1; load_idx = 6'd51; pte_hi = 32'hBBBB_B402; pte_lo = 32'h0000_0100;
        arr_wr_en = 1; arr_offs = {6'd51, 1'b0}; arr_wdata = 32'h0;
        @(posedge clk); #1;
        r_vpn[51] = 22'(32'hBBBB_B402 >> 10); r_asid[51] = 8'h02; r_ppn[51] = 0; r_attr[51] = 9'h100;
        idle();
        chk_read(0, 6'd51, "R11 load wins");
        // R10 invalidate keeps tags
        do_inval();
        chk_read(0, 6'd51, "R10");
        chk_lookup(32'hBBBB_B400, 8'h02, 0, 0, "R10 miss");

        // random phase
        for (int p = 0; p < 8; p++) pool[p] = 22'($urandom);
        for (int it = 0; it < 1500; it++) begin
            int op;
            logic [21:0] v;
            logic [31:0] lo;
            op = $urandom_range(0, 99);
            v = pool[$urandom_range(0, 7)] ^ 22'($urandom_range(0, 3) << $urandom_range(0, 9));
            lo = $urandom;
            if ($urandom_range(0, 9) < 7) lo[8] = 1'b1;
            if (op < 30) begin
                do_load(6'($urandom), {v, 2'b00, 8'($urandom_range(1, 3))}, lo);
            end else if (op < 36) begin
                do_arr($urandom_range(0, 1), 7'($urandom), {v, 10'($urandom)}, 8'($urandom_range(1, 3)));
            end else if (op < 38) begin
                do_inval();
            end else if (op < 44) begin
                chk_read($urandom_range(0, 1), 6'($urandom), "rand R7");
            end else begin
                chk_lookup({v, 10'($urandom)}, 8'($urandom_range(1, 3)),
                           $urandom_range(0, 1), $urandom_range(0, 1), "rand R1 R2 R4");
            end
        end
        finish_run();
    end

endmodule